// File: doc/BRIEF.md
# Sector ECC Status Reporter

This block sits behind a per-sector Hamming checker in a NAND page-read path. Each time the checker finishes one 512-byte sector it pulses a done strobe together with two 2-bit result codes, one for the sector's main data and one for its spare bytes, plus the byte offset and bit index of any single-bit error it located. The block files both results into that sector's 4-bit nibble of a status word the host reads after the page. A double-bit result in either field raises a sticky page-level flag.

Single-bit errors need no software step. The block issues a one-cycle write strobe with a page-buffer byte address and a one-hot bit mask, and the buffer flips that bit. Main-area addresses run from zero through the sector data. Spare addresses follow all main data, 16 bytes per sector. Spare bytes inside the check-code window (offsets 6 to 10 by default) carry code rather than data and are not rewritten. Upstream keeps done strobes at least two cycles apart so that a second repair for the same sector can drain.

Top module: `sec_ecc_status`

## Requirements
- R1: After reset, `ecc_status` is all zero, `uncorr_flag` is low and `fix_we` is low.
- R2: A `sector_done` pulse for sector i writes the main-area result to bits 4i+1:4i and the spare-area result to bits 4i+3:4i+2 of `ecc_status`. The new value is visible in the cycle after the strobe's clock edge, and the nibbles of the other sectors keep their values.
- R3: The field codes are 0 for clean, 1 for a repaired single-bit error and 2 for uncorrectable. An input code of 3 is stored as 2 and handled as uncorrectable, so no field ever reads 3.
- R4: `uncorr_flag` rises after any sector whose main or spare field is uncorrectable, and it stays high until `page_start`.
- R5: `page_start` clears every status field and `uncorr_flag`. A `sector_done` in the same cycle is applied on top of the cleared state.
- R6: A correctable main-area result gives one cycle of `fix_we` with `fix_addr` = sector*512 + byte offset and `fix_mask` = 1 << bit index.
- R7: A correctable spare-area result writes to `fix_addr` = SECTORS*512 + sector*16 + spare byte offset, with a one-hot `fix_mask`.
- R8: When both fields of one sector are correctable, the main-area write comes in the first cycle after the strobe and the spare-area write in the cycle after that.
- R9: A correctable spare error at an offset inside the check-code window (6 to 10) reports code 1 but issues no buffer write. Offsets outside the window are written.
- R10: A sector with any uncorrectable field issues no buffer write, even if its other field is correctable.
- R11: A sector with both fields clean issues no buffer write.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| page_start | input | 1 | A new page read begins; clears the page results |
| sector_done | input | 1 | The checker finished one sector; results are valid |
| sector_idx | input | SEC_W | Index of the finished sector |
| main_code | input | 2 | Main-area result code |
| spare_code | input | 2 | Spare-area result code |
| main_err_byte | input | MAIN_W | Byte offset of the main-area single-bit error |
| main_err_bit | input | 3 | Bit index of the main-area single-bit error |
| spare_err_byte | input | SPARE_W | Byte offset of the spare-area single-bit error |
| spare_err_bit | input | 3 | Bit index of the spare-area single-bit error |
| ecc_status | output | SECTORS*4 | Per-sector result nibbles |
| uncorr_flag | output | 1 | Sticky uncorrectable flag for the page |
| fix_we | output | 1 | Bit-repair write strobe to the page buffer |
| fix_addr | output | ADDR_W | Page-buffer byte address of the repair |
| fix_mask | output | 8 | One-hot mask of the bit to flip |

## Verification
A corrupted nibble or a lost sticky flag shows on `ecc_status` or `uncorr_flag` in the cycle after the strobe that caused it. It also persists through later sectors, so sampling after every sector localises the fault to the strobe that caused it. A wrong repair address, a wrong mask or a stuck pending slot shows up one or two cycles after the strobe as a misplaced, missing or extra `fix_we` pulse. For that reason the bench samples the strobe in both of the cycles that follow each sector.

// File: rtl/sec_ecc_pkg.sv
package sec_ecc_pkg;

    typedef enum logic [1:0] {
        ECC_CLEAN = 2'd0,
        ECC_FIXED = 2'd1,
        ECC_FATAL = 2'd2
    } ecc_res_e;

    // Reserved code 3 folds into the uncorrectable class.
    function automatic ecc_res_e fold_code(input logic [1:0] raw);
        ecc_res_e r;
        case (raw)
            2'd0:    r = ECC_CLEAN;
            2'd1:    r = ECC_FIXED;
            default: r = ECC_FATAL;
        endcase
        return r;
    endfunction

endpackage

// File: rtl/ecc_field_class.sv
module ecc_field_class
    import sec_ecc_pkg::*;
(
    input  logic [1:0] raw_code,
    output logic [1:0] field_val,
    output logic       is_fixed,
    output logic       is_fatal
);

    ecc_res_e res;

    always_comb begin
        res       = fold_code(raw_code);
        field_val = res;
        is_fixed  = (res == ECC_FIXED);
        is_fatal  = (res == ECC_FATAL);
    end

endmodule

// File: rtl/ecc_fix_locator.sv
module ecc_fix_locator #(
    parameter int SECTORS      = 4,
    parameter int SECTOR_BYTES = 512,
    parameter int SPARE_BYTES  = 16,
    parameter int CODE_POS     = 6,
    parameter int CODE_LEN     = 5,
    localparam int SEC_W   = (SECTORS > 1) ? $clog2(SECTORS) : 1,
    localparam int MAIN_W  = $clog2(SECTOR_BYTES),
    localparam int SPARE_W = $clog2(SPARE_BYTES),
    localparam int ADDR_W  = $clog2(SECTORS * (SECTOR_BYTES + SPARE_BYTES))
) (
    input  logic [SEC_W-1:0]   sector,
    input  logic [MAIN_W-1:0]  main_byte,
    input  logic [2:0]         main_bit,
    input  logic [SPARE_W-1:0] spare_byte,
    input  logic [2:0]         spare_bit,
    output logic [ADDR_W-1:0]  main_addr,
    output logic [7:0]         main_mask,
    output logic [ADDR_W-1:0]  spare_addr,
    output logic [7:0]         spare_mask,
    output logic               spare_in_code
);

    localparam int SPARE_BASE = SECTORS * SECTOR_BYTES;

    always_comb begin
        main_addr  = ADDR_W'(int'(sector) * SECTOR_BYTES + int'(main_byte));
        spare_addr = ADDR_W'(SPARE_BASE + int'(sector) * SPARE_BYTES + int'(spare_byte));
        main_mask  = 8'd1 << main_bit;
        spare_mask = 8'd1 << spare_bit;
        spare_in_code = (int'(spare_byte) >= CODE_POS) &&
                        (int'(spare_byte) <  CODE_POS + CODE_LEN);
    end

endmodule

// File: rtl/sec_ecc_status.sv
module sec_ecc_status #(
    parameter int SECTORS      = 4,
    parameter int SECTOR_BYTES = 512,
    parameter int SPARE_BYTES  = 16,
    parameter int CODE_POS     = 6,
    parameter int CODE_LEN     = 5,
    localparam int SEC_W   = (SECTORS > 1) ? $clog2(SECTORS) : 1,
    localparam int MAIN_W  = $clog2(SECTOR_BYTES),
    localparam int SPARE_W = $clog2(SPARE_BYTES),
    localparam int ADDR_W  = $clog2(SECTORS * (SECTOR_BYTES + SPARE_BYTES)),
    localparam int STAT_W  = SECTORS * 4
) (
    input  logic               clk,
    input  logic               rst_n,
    input  logic               page_start,
    input  logic               sector_done,
    input  logic [SEC_W-1:0]   sector_idx,
    input  logic [1:0]         main_code,
    input  logic [1:0]         spare_code,
    input  logic [MAIN_W-1:0]  main_err_byte,
    input  logic [2:0]         main_err_bit,
    input  logic [SPARE_W-1:0] spare_err_byte,
    input  logic [2:0]         spare_err_bit,
    output logic [STAT_W-1:0]  ecc_status,
    output logic               uncorr_flag,
    output logic               fix_we,
    output logic [ADDR_W-1:0]  fix_addr,
    output logic [7:0]         fix_mask
);

    typedef struct packed {
        logic [STAT_W-1:0] status;
        logic              uncorr;
        logic              fix_we;
        logic [ADDR_W-1:0] fix_addr;
        logic [7:0]        fix_mask;
        logic              pend;
        logic [ADDR_W-1:0] pend_addr;
        logic [7:0]        pend_mask;
    } state_t;

    state_t st_d, st_q;

    // index 0 = main area, index 1 = spare area
    logic [1:0] raw_code [2];
    logic [1:0] field_val [2];
    logic       is_fixed [2];
    logic       is_fatal [2];

    assign raw_code[0] = main_code;
    assign raw_code[1] = spare_code;

    for (genvar f = 0; f < 2; f++) begin : g_field
        ecc_field_class u_class (
            .raw_code  (raw_code[f]),
            .field_val (field_val[f]),
            .is_fixed  (is_fixed[f]),
            .is_fatal  (is_fatal[f])
        );
    end

    logic [ADDR_W-1:0] main_addr, spare_addr;
    logic [7:0]        main_mask, spare_mask;
    logic              spare_in_code;

    ecc_fix_locator #(
        .SECTORS      (SECTORS),
        .SECTOR_BYTES (SECTOR_BYTES),
        .SPARE_BYTES  (SPARE_BYTES),
        .CODE_POS     (CODE_POS),
        .CODE_LEN     (CODE_LEN)
    ) u_loc (
        .sector        (sector_idx),
        .main_byte     (main_err_byte),
        .main_bit      (main_err_bit),
        .spare_byte    (spare_err_byte),
        .spare_bit     (spare_err_bit),
        .main_addr     (main_addr),
        .main_mask     (main_mask),
        .spare_addr    (spare_addr),
        .spare_mask    (spare_mask),
        .spare_in_code (spare_in_code)
    );

    logic sector_fail;
    logic spare_repair;

    always_comb begin
        sector_fail  = is_fatal[0] | is_fatal[1];
        spare_repair = is_fixed[1] & ~spare_in_code;

        st_d          = st_q;
        st_d.fix_we   = 1'b0;
        st_d.fix_mask = '0;

        // Drain a deferred spare repair first.
        if (st_q.pend) begin
            st_d.fix_we   = 1'b1;
            st_d.fix_addr = st_q.pend_addr;
            st_d.fix_mask = st_q.pend_mask;
            st_d.pend     = 1'b0;
        end

        if (page_start) begin
            st_d.status = '0;
            st_d.uncorr = 1'b0;
        end

        if (sector_done && (int'(sector_idx) < SECTORS)) begin
            st_d.status[int'(sector_idx)*4 +: 4] = {field_val[1], field_val[0]};
            if (sector_fail) begin
                st_d.uncorr = 1'b1;
            end else if (is_fixed[0]) begin
                st_d.fix_we   = 1'b1;
                st_d.fix_addr = main_addr;
                st_d.fix_mask = main_mask;
                if (spare_repair) begin
                    st_d.pend      = 1'b1;
                    st_d.pend_addr = spare_addr;
                    st_d.pend_mask = spare_mask;
                end
            end else if (spare_repair) begin
                st_d.fix_we   = 1'b1;
                st_d.fix_addr = spare_addr;
                st_d.fix_mask = spare_mask;
            end
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            st_q <= '0;
        end else begin
            st_q <= st_d;
        end
    end

    assign ecc_status  = st_q.status;
    assign uncorr_flag = st_q.uncorr;
    assign fix_we      = st_q.fix_we;
    assign fix_addr    = st_q.fix_addr;
    assign fix_mask    = st_q.fix_mask;

endmodule

// File: rtl/sec_ecc_status_chk.sv
module sec_ecc_status_chk #(
    parameter int SECTORS = 4,
    localparam int STAT_W = SECTORS * 4
) (
    input logic              clk,
    input logic              rst_n,
    input logic              page_start,
    input logic              sector_done,
    input logic [1:0]        main_code,
    input logic [1:0]        spare_code,
    input logic [STAT_W-1:0] ecc_status,
    input logic              uncorr_flag,
    input logic              fix_we,
    input logic [7:0]        fix_mask
);

    for (genvar g = 0; g < SECTORS * 2; g++) begin : g_field_chk
        // R3
        field_not_reserved_chk: assert property (@(posedge clk) disable iff (!rst_n)
            ecc_status[2*g +: 2] != 2'd3);
    end

    // R4
    uncorr_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (uncorr_flag && !page_start) |=> uncorr_flag);

    // R4
    uncorr_set_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (sector_done && (main_code[1] || spare_code[1])) |=> uncorr_flag);

    // R5
    page_clear_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (page_start && !sector_done) |=> (ecc_status == '0 && !uncorr_flag));

    // R6
    fix_mask_onehot_chk: assert property (@(posedge clk) disable iff (!rst_n)
        fix_we |-> ($countones(fix_mask) == 1));

    // R8
    fix_source_chk: assert property (@(posedge clk) disable iff (!rst_n)
        fix_we |-> ($past(sector_done) || $past(fix_we)));

    // R10
    fail_no_fix_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (sector_done && (main_code[1] || spare_code[1])) |=> !fix_we);

    // R11
    clean_no_fix_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (sector_done && main_code == 2'd0 && spare_code == 2'd0) |=> !fix_we);

endmodule

bind sec_ecc_status sec_ecc_status_chk #(.SECTORS(SECTORS)) u_chk (
    .clk         (clk),
    .rst_n       (rst_n),
    .page_start  (page_start),
    .sector_done (sector_done),
    .main_code   (main_code),
    .spare_code  (spare_code),
    .ecc_status  (ecc_status),
    .uncorr_flag (uncorr_flag),
    .fix_we      (fix_we),
    .fix_mask    (fix_mask)
);

// File: tb/sec_ecc_status_tb.sv
module sec_ecc_status_tb;

    localparam int CLK_PERIOD = 10;
    localparam int SECTORS    = 4;
    localparam int SEC_W      = 2;
    localparam int MAIN_W     = 9;
    localparam int SPARE_W    = 4;
    localparam int ADDR_W     = 12;
    localparam int SPARE_BASE = SECTORS * 512;

    logic               clk = 1'b0;
    logic               rst_n = 1'b0;
    logic               page_start = 1'b0;
    logic               sector_done = 1'b0;
    logic [SEC_W-1:0]   sector_idx = '0;
    logic [1:0]         main_code = '0;
    logic [1:0]         spare_code = '0;
    logic [MAIN_W-1:0]  main_err_byte = '0;
    logic [2:0]         main_err_bit = '0;
    logic [SPARE_W-1:0] spare_err_byte = '0;
    logic [2:0]         spare_err_bit = '0;
    logic [15:0]        ecc_status;
    logic               uncorr_flag;
    logic               fix_we;
    logic [ADDR_W-1:0]  fix_addr;
    logic [7:0]         fix_mask;

    int n_checks = 0;
    int n_fail   = 0;

    always #(CLK_PERIOD/2) clk = ~clk;

    sec_ecc_status #(.SECTORS(SECTORS)) u_dut (
        .clk            (clk),
        .rst_n          (rst_n),
        .page_start     (page_start),
        .sector_done    (sector_done),
        .sector_idx     (sector_idx),
        .main_code      (main_code),
        .spare_code     (spare_code),
        .main_err_byte  (main_err_byte),
        .main_err_bit   (main_err_bit),
        .spare_err_byte (spare_err_byte),
        .spare_err_bit  (spare_err_bit),
        .ecc_status     (ecc_status),
        .uncorr_flag    (uncorr_flag),
        .fix_we         (fix_we),
        .fix_addr       (fix_addr),
        .fix_mask       (fix_mask)
    );

    task automatic chk(input string req, input logic [63:0] act, input logic [63:0] exp);
        n_checks++;
        if (act !== exp) begin
            n_fail++;
            $display("FAIL %s: actual 0x%0h expected 0x%0h", req, act, exp);
        end
    endtask

    // Pulse one sector result; returns sampled in first and second cycle after.
    task automatic run_sector(input int idx, input int mc, input int sc,
                              input int mb, input int mbit, input int sb, input int sbit,
                              input bit with_page,
                              output logic we1, output logic [ADDR_W-1:0] a1, output logic [7:0] m1,
                              output logic we2, output logic [ADDR_W-1:0] a2, output logic [7:0] m2);
        @(negedge clk);
        sector_idx     = SEC_W'(idx);
        main_code      = 2'(mc);
        spare_code     = 2'(sc);
        main_err_byte  = MAIN_W'(mb);
        main_err_bit   = 3'(mbit);
        spare_err_byte = SPARE_W'(sb);
        spare_err_bit  = 3'(sbit);
        sector_done    = 1'b1;
        page_start     = with_page;
        @(negedge clk);
        sector_done = 1'b0;
        page_start  = 1'b0;
        we1 = fix_we; a1 = fix_addr; m1 = fix_mask;
        @(negedge clk);
        we2 = fix_we; a2 = fix_addr; m2 = fix_mask;
    endtask

    task automatic new_page();
        @(negedge clk);
        page_start = 1'b1;
        @(negedge clk);
        page_start = 1'b0;
    endtask

    task automatic t_reset();
        chk("R1 status", ecc_status, 0);
        chk("R1 uncorr", uncorr_flag, 0);
        chk("R1 fix_we", fix_we, 0);
    endtask

    task automatic t_clean();
        logic w1, w2; logic [ADDR_W-1:0] a1, a2; logic [7:0] m1, m2;
        run_sector(0, 0, 0, 5, 1, 2, 1, 0, w1, a1, m1, w2, a2, m2);
        chk("R11 no write c1", w1, 0);
        chk("R11 no write c2", w2, 0);
        chk("R2 clean nibble", ecc_status, 16'h0000);
    endtask

    task automatic t_main_fix();
        logic w1, w2; logic [ADDR_W-1:0] a1, a2; logic [7:0] m1, m2;
        run_sector(1, 1, 0, 'h1A3, 5, 0, 0, 0, w1, a1, m1, w2, a2, m2);
        chk("R6 we", w1, 1);
        chk("R6 addr", a1, 512 + 'h1A3);
        chk("R6 mask", m1, 8'h20);
        chk("R6 single pulse", w2, 0);
        chk("R2 main field sector1", ecc_status, 16'h0010);
    endtask

    task automatic t_spare_fix();
        logic w1, w2; logic [ADDR_W-1:0] a1, a2; logic [7:0] m1, m2;
        run_sector(2, 0, 1, 0, 0, 3, 0, 0, w1, a1, m1, w2, a2, m2);
        chk("R7 we", w1, 1);
        chk("R7 addr", a1, SPARE_BASE + 2*16 + 3);
        chk("R7 mask", m1, 8'h01);
        chk("R7 single pulse", w2, 0);
        chk("R2 spare field sector2", ecc_status, 16'h0410);
    endtask

    task automatic t_both_fix();
        logic w1, w2; logic [ADDR_W-1:0] a1, a2; logic [7:0] m1, m2;
        run_sector(3, 1, 1, 7, 7, 14, 2, 0, w1, a1, m1, w2, a2, m2);
        chk("R8 first we", w1, 1);
        chk("R8 first is main addr", a1, 3*512 + 7);
        chk("R8 first mask", m1, 8'h80);
        chk("R8 second we", w2, 1);
        chk("R8 second is spare addr", a2, SPARE_BASE + 3*16 + 14);
        chk("R8 second mask", m2, 8'h04);
        chk("R2 all nibbles kept", ecc_status, 16'h5410);
        @(negedge clk);
        chk("R8 no third write", fix_we, 0);
    endtask

    task automatic t_code_window();
        logic w1, w2; logic [ADDR_W-1:0] a1, a2; logic [7:0] m1, m2;
        new_page();
        run_sector(0, 0, 1, 0, 0, 6, 3, 0, w1, a1, m1, w2, a2, m2);
        chk("R9 offset 6 status", ecc_status, 16'h0004);
        chk("R9 offset 6 no write", w1 | w2, 0);
        run_sector(1, 0, 1, 0, 0, 10, 3, 0, w1, a1, m1, w2, a2, m2);
        chk("R9 offset 10 no write", w1 | w2, 0);
        run_sector(2, 0, 1, 0, 0, 11, 6, 0, w1, a1, m1, w2, a2, m2);
        chk("R9 offset 11 written", w1, 1);
        chk("R9 offset 11 addr", a1, SPARE_BASE + 2*16 + 11);
        run_sector(3, 0, 1, 0, 0, 5, 4, 0, w1, a1, m1, w2, a2, m2);
        chk("R9 offset 5 written", w1, 1);
        chk("R9 offset 5 mask", m1, 8'h10);
    endtask

    task automatic t_uncorr();
        logic w1, w2; logic [ADDR_W-1:0] a1, a2; logic [7:0] m1, m2;
        new_page();
        chk("R5 cleared status", ecc_status, 0);
        chk("R5 cleared flag", uncorr_flag, 0);
        run_sector(1, 2, 1, 9, 1, 2, 1, 0, w1, a1, m1, w2, a2, m2);
        chk("R4 flag set", uncorr_flag, 1);
        chk("R10 no write on failed sector", w1 | w2, 0);
        chk("R2 failed nibble", ecc_status, 16'h0060);
        run_sector(2, 0, 0, 0, 0, 0, 0, 0, w1, a1, m1, w2, a2, m2);
        chk("R4 flag sticky", uncorr_flag, 1);
        run_sector(0, 1, 2, 4, 2, 0, 0, 0, w1, a1, m1, w2, a2, m2);
        chk("R10 main fix suppressed", w1 | w2, 0);
    endtask

    task automatic t_reserved();
        logic w1, w2; logic [ADDR_W-1:0] a1, a2; logic [7:0] m1, m2;
        new_page();
        run_sector(3, 0, 3, 0, 0, 1, 1, 0, w1, a1, m1, w2, a2, m2);
        chk("R3 code 3 stored as 2", ecc_status, 16'h8000);
        chk("R3 code 3 raises flag", uncorr_flag, 1);
        run_sector(2, 3, 0, 0, 0, 0, 0, 0, w1, a1, m1, w2, a2, m2);
        chk("R3 main code 3 stored as 2", ecc_status, 16'h8200);
    endtask

    task automatic t_page_overlap();
        logic w1, w2; logic [ADDR_W-1:0] a1, a2; logic [7:0] m1, m2;
        // Status holds 0x8200 with flag set; page_start plus a new result.
        run_sector(1, 1, 0, 3, 3, 0, 0, 1, w1, a1, m1, w2, a2, m2);
        chk("R5 same-cycle sector on cleared page", ecc_status, 16'h0010);
        chk("R5 flag cleared", uncorr_flag, 0);
        chk("R6 overlap write addr", a1, 512 + 3);
        run_sector(2, 2, 0, 0, 0, 0, 0, 1, w1, a1, m1, w2, a2, m2);
        chk("R5 same-cycle fatal sets flag", uncorr_flag, 1);
        chk("R5 same-cycle fatal status", ecc_status, 16'h0200);
    endtask

    initial begin : watchdog
        repeat (5000) @(posedge clk);
        n_checks++;
        n_fail++;
        $display("FAIL watchdog: actual timeout expected completion");
        $display("  == %0d vectors applied, %0d miscompares ==", n_checks, n_fail);
        $finish;
    end

    initial begin : main
        repeat (3) @(negedge clk);
        rst_n = 1'b1;
        @(negedge clk);
        t_reset();
        t_clean();
        t_main_fix();
        t_spare_fix();
        t_both_fix();
        t_code_window();
        t_uncorr();
        t_reserved();
        t_page_overlap();
        $display("  == %0d vectors applied, %0d miscompares ==", n_checks, n_fail);
        $finish;
    end

endmodule